// File: doc/BRIEF.md
# Register Result-Status Rename Table

This block holds an architectural register file together with a producer-tag table that has one entry per register. When an instruction issues, the block looks up both source registers. A source with no pending producer comes back as a ready value with tag zero. A source that still has a pending producer comes back as that producer's tag, which the consuming station later matches against the result bus. If the issue has a destination, the issuing station's tag is written into that register's entry. Any earlier producer of the same register is dropped from the table at that moment, so write-after-read and write-after-write hazards never stall issue.

On every cycle the block watches the shared result bus, which carries one 64-bit result and a 4-bit source tag. A register takes the bus value only while its entry still names that tag, and the entry is then cleared. A result from a producer that has been superseded is therefore dropped. The operand outputs are registered and appear one clock after the issue. They keep their value while no issue is active.

Top module: `rename_table`

## Requirements
- R1: After a synchronous active-high reset, every register reads as value 0 with tag 0, and no register has a pending producer.
- R2: A source register whose entry is blank (tag 0) returns its stored value with tag 0 on opX_val/opX_tag in the cycle after the issue.
- R3: A source register with a pending producer returns that producer's 4-bit tag, and its value output is zero.
- R4: An issue with iss_wr high writes iss_tag (never 0) into the entry of iss_dst. A later rename of the same register replaces the earlier tag.
- R5: A bus transfer with a nonzero tag stores cdb_data into every register whose entry equals cdb_tag and clears those entries. All other registers stay unchanged.
- R6: A bus transfer whose tag no longer matches a register's entry, because that register was renamed again, changes neither the value nor the entry of that register.
- R7: When a source is read in the same cycle that the bus carries the tag pending on it, the read returns cdb_data with tag 0.
- R8: When a rename and a matching bus transfer hit the same register in the same cycle, the entry takes the new tag and the register value keeps its old contents.
- R9: A source that equals the destination of the same issue sees the state from before that issue's rename.
- R10: A bus transfer with tag 0 writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue active: perform the source lookups |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| iss_wr | input | 1 | Issue has a destination to rename |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station, nonzero |
| cdb_vld | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_data | input | 64 | Result value |
| opa_val | output | 64 | First operand value, zero when pending |
| opa_tag | output | 4 | First operand producer tag, 0 when ready |
| opb_val | output | 64 | Second operand value, zero when pending |
| opb_tag | output | 4 | Second operand producer tag, 0 when ready |

## Verification
A corrupted producer entry shows up at the next lookup of that register. It appears either as the wrong tag or as a tag where a value was expected, one cycle after the issue that reads it. A bad write enable leaves a stale or premature value in a register. That error stays hidden until a later issue reads the register, so the bench reads every register after each broadcast sweep, and the long stimulus phase compares every lookup against a model built from the requirements.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned RT_NREG   = 16;
  localparam int unsigned RT_TAG_W  = 4;
  localparam int unsigned RT_DATA_W = 64;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_PEND = 2'd2
  } src_sel_e;
endpackage

// File: rtl/rt_status.sv
module rt_status #(
  parameter int unsigned NREG  = 16,
  parameter int unsigned TAG_W = 4,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ren_vld,
  input  logic [IDX_W-1:0] ren_dst,
  input  logic [TAG_W-1:0] ren_tag,
  input  logic             bus_vld,
  input  logic [TAG_W-1:0] bus_tag,
  output logic [TAG_W-1:0] stat_o [NREG],
  output logic             wen_o  [NREG]
);
  logic [TAG_W-1:0] stat_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    logic hit, ren;
    assign hit = bus_vld && (bus_tag != '0) && (stat_q[k] == bus_tag);
    assign ren = ren_vld && (ren_dst == IDX_W'(k));
    assign wen_o[k]  = hit && !ren;
    assign stat_o[k] = stat_q[k];

    always_ff @(posedge clk) begin
      if (rst)      stat_q[k] <= '0;
      else if (ren) stat_q[k] <= ren_tag;
      else if (hit) stat_q[k] <= '0;
    end

    AST_BUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (bus_vld && bus_tag != '0 && stat_q[k] == bus_tag && !ren) |=> stat_q[k] == '0); // R5
    AST_RENAME_WINS: assert property (@(posedge clk) disable iff (rst)
      (ren_vld && ren_dst == IDX_W'(k)) |=> stat_q[k] == $past(ren_tag)); // R8
    AST_STALE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!(ren_vld && ren_dst == IDX_W'(k)) && !(bus_vld && stat_q[k] == bus_tag && bus_tag != '0))
      |=> $stable(stat_q[k])); // R6
  end
endmodule

// File: rtl/rt_values.sv
module rt_values #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen    [NREG],
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] val_o  [NREG]
);
  // Flat array with a common write datum; every entry loads the same bus word.
  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)         mem_q[k] <= '0;
      else if (wen[k]) mem_q[k] <= bus_data;
    end
    assign val_o[k] = mem_q[k];

    AST_VAL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wen[k] |=> $stable(mem_q[k])); // R6
    AST_VAL_LOAD: assert property (@(posedge clk) disable iff (rst)
      wen[k] |=> mem_q[k] == $past(bus_data)); // R5
  end
endmodule

// File: rtl/rt_src_port.sv
module rt_src_port
  import rt_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [DATA_W-1:0] ent_val,
  input  logic              bus_vld,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] op_val,
  output logic [TAG_W-1:0]  op_tag
);
  src_sel_e sel;

  always_comb begin
    if (ent_tag == '0)                         sel = SRC_REG;
    else if (bus_vld && bus_tag == ent_tag)    sel = SRC_BUS;
    else                                       sel = SRC_PEND;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_val <= '0;
      op_tag <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SRC_REG:  begin op_val <= ent_val;  op_tag <= '0;      end
        SRC_BUS:  begin op_val <= bus_data; op_tag <= '0;      end
        default:  begin op_val <= '0;       op_tag <= ent_tag; end
      endcase
    end
  end

  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ent_tag != '0 && bus_vld && bus_tag == ent_tag)
    |=> (op_tag == '0 && op_val == $past(bus_data))); // R7
  AST_PEND_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_tag != '0) |-> (op_val == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(op_val) && $stable(op_tag))); // R2
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rt_pkg::*;
#(
  parameter int unsigned NREG   = RT_NREG,
  parameter int unsigned TAG_W  = RT_TAG_W,
  parameter int unsigned DATA_W = RT_DATA_W,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_vld,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic              iss_wr,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_vld,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [DATA_W-1:0] opa_val,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opb_val,
  output logic [TAG_W-1:0]  opb_tag
);
  localparam int unsigned NPORT = 2;

  logic [TAG_W-1:0]  stat [NREG];
  logic              wen  [NREG];
  logic [DATA_W-1:0] vals [NREG];
  logic              ren_vld;

  logic [IDX_W-1:0]  src_idx [NPORT];
  logic [DATA_W-1:0] p_val   [NPORT];
  logic [TAG_W-1:0]  p_tag   [NPORT];

  assign ren_vld    = iss_vld && iss_wr;
  assign src_idx[0] = iss_src_a;
  assign src_idx[1] = iss_src_b;

  rt_status #(.NREG(NREG), .TAG_W(TAG_W)) u_status (
    .clk(clk), .rst(rst),
    .ren_vld(ren_vld), .ren_dst(iss_dst), .ren_tag(iss_tag),
    .bus_vld(cdb_vld), .bus_tag(cdb_tag),
    .stat_o(stat), .wen_o(wen)
  );

  rt_values #(.NREG(NREG), .DATA_W(DATA_W)) u_values (
    .clk(clk), .rst(rst), .wen(wen), .bus_data(cdb_data), .val_o(vals)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rt_src_port #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_port (
      .clk(clk), .rst(rst), .rd_en(iss_vld),
      .ent_tag(stat[src_idx[p]]), .ent_val(vals[src_idx[p]]),
      .bus_vld(cdb_vld), .bus_tag(cdb_tag), .bus_data(cdb_data),
      .op_val(p_val[p]), .op_tag(p_tag[p])
    );
  end

  assign opa_val = p_val[0];
  assign opa_tag = p_tag[0];
  assign opb_val = p_val[1];
  assign opb_tag = p_tag[1];

  AST_ISSUE_TAG_NZ: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && iss_wr) |-> iss_tag != '0); // R4
  AST_RESET_BLANK: assert property (@(posedge clk)
    rst |=> (opa_tag == '0 && opb_tag == '0 && opa_val == '0 && opb_val == '0)); // R1
endmodule

// File: tb/sim_rename_table.sv
module sim_rename_table;
  logic        clk = 1'b0;
  logic        rst;
  logic        iss_vld, iss_wr, cdb_vld;
  logic [3:0]  iss_src_a, iss_src_b, iss_dst, iss_tag, cdb_tag;
  logic [63:0] cdb_data;
  logic [63:0] opa_val, opb_val;
  logic [3:0]  opa_tag, opb_tag;

  int checks = 0;
  int errors = 0;

  logic [3:0]  m_stat [16];
  logic [63:0] m_val  [16];

  always #4 clk = ~clk;

  rename_table u0 (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_wr(iss_wr), .iss_dst(iss_dst), .iss_tag(iss_tag), .cdb_vld(cdb_vld),
    .cdb_tag(cdb_tag), .cdb_data(cdb_data), .opa_val(opa_val), .opa_tag(opa_tag),
    .opb_val(opb_val), .opb_tag(opb_tag)
  );

  function automatic logic [63:0] pat(input int a, input int b);
    return 64'h0F1E_2D3C_4B5A_6978 ^ (64'(a) * 64'h0101_0000_0000_0011) ^ (64'(b) << 20);
  endfunction

  task automatic chk(input string req, input logic [63:0] av, input logic [3:0] at,
                     input logic [63:0] ev, input logic [3:0] et);
    checks++;
    if (av !== ev || at !== et) begin
      errors++;
      $display("FAIL %s: got val=%h tag=%0d expected val=%h tag=%0d", req, av, at, ev, et);
    end
  endtask

  task automatic predict(input int s, input logic cv, input logic [3:0] ct, input logic [63:0] cd,
                         output logic [63:0] v, output logic [3:0] t);
    if (m_stat[s] == 4'd0) begin v = m_val[s]; t = 4'd0; end
    else if (cv && ct == m_stat[s]) begin v = cd; t = 4'd0; end
    else begin v = 64'd0; t = m_stat[s]; end
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks results when reading.
  task automatic step(input logic iv, input int sa, input int sb, input logic wr, input int dst,
                      input logic [3:0] tg, input logic cv, input logic [3:0] ct,
                      input logic [63:0] cd, input string req);
    logic [63:0] eav, ebv;
    logic [3:0]  eat, ebt;
    logic        hit [16];
    iss_vld = iv; iss_src_a = 4'(sa); iss_src_b = 4'(sb); iss_wr = wr;
    iss_dst = 4'(dst); iss_tag = tg; cdb_vld = cv; cdb_tag = ct; cdb_data = cd;
    predict(sa, cv, ct, cd, eav, eat);
    predict(sb, cv, ct, cd, ebv, ebt);
    for (int k = 0; k < 16; k++) hit[k] = cv && ct != 4'd0 && m_stat[k] == ct;
    @(posedge clk);
    for (int k = 0; k < 16; k++)
      if (hit[k] && !(iv && wr && dst == k)) begin m_val[k] = cd; m_stat[k] = 4'd0; end
    if (iv && wr) m_stat[dst] = tg;
    @(negedge clk);
    iss_vld = 1'b0; cdb_vld = 1'b0; iss_wr = 1'b0;
    if (iv) begin
      chk({req, " port a"}, opa_val, opa_tag, eav, eat);
      chk({req, " port b"}, opb_val, opb_tag, ebv, ebt);
    end
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < 16; r += 2) step(1, r, r + 1, 0, 0, 4'd1, 0, 4'd0, 64'd0, req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; iss_vld = 0; iss_wr = 0; cdb_vld = 0;
    iss_src_a = 0; iss_src_b = 0; iss_dst = 0; iss_tag = 0; cdb_tag = 0; cdb_data = 0;
    for (int k = 0; k < 16; k++) begin m_stat[k] = 4'd0; m_val[k] = 64'd0; end
    repeat (3) @(negedge clk);
    chk("R1 reset outputs a", opa_val, opa_tag, 64'd0, 4'd0);
    chk("R1 reset outputs b", opb_val, opb_tag, 64'd0, 4'd0);
    rst = 1'b0;
    read_all("R1 R2 reset read");

    // R4 R3: rename every register, reading neighbours as it goes
    for (int r = 0; r < 16; r++)
      step(1, r, (r + 1) % 16, 1, r, 4'((r % 15) + 1), 0, 4'd0, 64'd0, "R4 R3 R9 rename sweep");
    read_all("R3 pending read");

    // R5: broadcast every tag, then read back
    for (int t = 1; t < 16; t++) step(0, 0, 0, 0, 0, 4'd1, 1, 4'(t), pat(t, 1), "R5 broadcast");
    read_all("R5 R2 after broadcast");

    // R10: bus tag zero writes nothing
    step(0, 0, 0, 0, 0, 4'd1, 1, 4'd0, 64'hDEAD_BEEF_0000_0001, "R10 tag zero");
    read_all("R10 no write from tag zero");

    // R6: write-after-write, stale result dropped
    step(1, 3, 3, 1, 3, 4'd5, 0, 4'd0, 64'd0, "R4 first rename");
    step(1, 3, 2, 1, 3, 4'd9, 0, 4'd0, 64'd0, "R4 second rename");
    step(0, 0, 0, 0, 0, 4'd1, 1, 4'd5, pat(5, 7), "R6 stale broadcast");
    step(1, 3, 3, 0, 0, 4'd1, 0, 4'd0, 64'd0, "R6 stale result dropped");
    step(0, 0, 0, 0, 0, 4'd1, 1, 4'd9, pat(9, 7), "R5 live broadcast");
    step(1, 3, 4, 0, 0, 4'd1, 0, 4'd0, 64'd0, "R5 live result stored");

    // R7: same-cycle bypass
    step(1, 4, 4, 1, 4, 4'd7, 0, 4'd0, 64'd0, "R4 rename for bypass");
    step(1, 4, 5, 0, 0, 4'd1, 1, 4'd7, pat(7, 3), "R7 bypass read");
    step(1, 4, 5, 0, 0, 4'd1, 0, 4'd0, 64'd0, "R7 value settled");

    // R8: rename collides with matching broadcast
    step(1, 6, 6, 1, 6, 4'd2, 0, 4'd0, 64'd0, "R4 rename before collision");
    step(1, 6, 7, 1, 6, 4'd11, 1, 4'd2, pat(2, 9), "R8 collision cycle");
    step(1, 6, 6, 0, 0, 4'd1, 0, 4'd0, 64'd0, "R8 new tag kept");
    step(0, 0, 0, 0, 0, 4'd1, 1, 4'd11, pat(11, 9), "R8 new producer broadcast");
    step(1, 6, 7, 0, 0, 4'd1, 0, 4'd0, 64'd0, "R8 old data was dropped");

    // R9: source equals destination in the same issue
    step(1, 8, 8, 1, 8, 4'd13, 0, 4'd0, 64'd0, "R9 source equals destination");
    step(1, 8, 8, 1, 8, 4'd14, 0, 4'd0, 64'd0, "R9 sees previous tag");

    // Broad mixed sweep
    for (int i = 0; i < 3000; i++) begin
      int unsigned rv;
      rv = $urandom;
      step(rv[0] | rv[1], int'(rv[5:2]), int'(rv[9:6]), rv[10], int'(rv[14:11]),
           4'(1 + (rv[19:15] % 15)), rv[20] | rv[21], 4'(rv[25:22]),
           pat(int'(rv[31:22]), i), "R2 R3 R5 R7 mixed");
    end
    read_all("R5 R6 final state");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule